// File: doc/BRIEF.md
# UART Interrupt Identification Register

This block gathers the interrupt conditions of a 16550-style serial port and reports them through one read-only 8-bit identification value plus a single interrupt request line. Four prioritised levels share a two-bit source code in bits 2:1, with an active-low pending flag in bit 0. A receive time-out shares the receive-data level and also sets bit 3. Bit 4 reports autobaud lock. Bits 7:6 report whether FIFO mode is on, and bit 5 is always zero.

The identification value is registered. Every clock edge takes in the conditions, enables and mode inputs, and the new value appears after that edge. A register-read strobe tells the block that software has read the value. If the value read was showing a transmit request, that request is acknowledged.

The acknowledge is tracked by a two-state machine. `TXS_LIVE` means a transmit request may raise an interrupt. `TXS_ACKED` means the current request has been read and is masked. The machine has two transitions:
- `LIVE->ACKED` is taken on a read while the transmit code is shown.
- `ACKED->LIVE` is taken when the transmit condition goes away.

All other sources clear only when their condition clears.

Top module: `uirq_ident`

## Requirements
- R1: After reset with all inputs inactive, `id_reg` reads 0x01 and `irq` is 0.
- R2: Bit 0 is 0 exactly when at least one enabled prioritised source (or an enabled time-out in FIFO mode) is pending. When bit 0 is 1, bits 3:1 are 0.
- R3: The source code in bits 2:1 is 11 for receive error, 10 for receive data, 01 for transmit request and 00 for modem change. Bits 3:0 therefore read 0x6, 0x4, 0x2 or 0x0.
- R4: When several sources are pending, bits 3:0 show only the highest one. The order, highest first, is receive error, then receive data/time-out, then transmit request, then modem change.
- R5: A time-out counts only when FIFO mode is on and `src_en[2]` is set. When it wins, bits 3:0 read 0xC, and this takes precedence over plain receive data. In every other case bit 3 is 0.
- R6: A source whose enable bit is 0 never affects bits 3:0. The enable bits are `src_en[3]` error, `[2]` receive data/time-out, `[1]` transmit, `[0]` modem.
- R7: Bit 4 equals `ab_lock` as sampled at the previous edge, whatever the pending flag shows.
- R8: Bits 7:6 read 11 when `fifo_mode` was 1 and 00 when it was 0. Bit 5 reads 0.
- R9: A read strobe while bits 3:0 show 0x2 clears the transmit interrupt from the next value on. It stays cleared while the transmit condition stays high, and it re-arms once the condition has dropped and risen again.
- R10: A read strobe while bits 3:0 show anything other than 0x2 leaves the transmit request pending.
- R11: `irq` is the inverse of bit 0, and both take effect one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 4 | Per-level enables: [3] error, [2] receive data and time-out, [1] transmit, [0] modem |
| c_rxerr | input | 1 | Receive error condition |
| c_rxdat | input | 1 | Receive data available condition |
| c_tmo | input | 1 | Receive time-out condition |
| c_txreq | input | 1 | Transmit FIFO requests data |
| c_modem | input | 1 | Modem line change condition |
| fifo_mode | input | 1 | FIFO mode is enabled |
| ab_lock | input | 1 | Autobaud logic has loaded the divisor |
| rd_stb | input | 1 | Identification register is being read this cycle |
| id_reg | output | 8 | Identification value |
| irq | output | 1 | Registered interrupt request |

## Verification
Every result of this block is due exactly one clock after the inputs that caused it. This includes the priority code, the status bits, the `irq` line and the effect of a read strobe on the transmit acknowledge.

The bench drives inputs on the falling edge. Before each rising edge it updates a behavioural model from those inputs and the value it expects to be showing at that moment. It then compares every field 1 ns after the edge.

The bench sweeps every combination of the five conditions under all sixteen enable patterns and both modes, with reads mixed in. Targeted sequences then exercise acknowledge, re-arm and the no-effect read.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC   = 4;
    localparam int CODE_W = $clog2(NSRC);
    localparam int REG_W  = 8;

    localparam logic [CODE_W-1:0] CODE_MODEM = 2'd0;
    localparam logic [CODE_W-1:0] CODE_TX    = 2'd1;
    localparam logic [CODE_W-1:0] CODE_RX    = 2'd2;
    localparam logic [CODE_W-1:0] CODE_ERR   = 2'd3;

    typedef enum logic {
        TXS_LIVE  = 1'b0,
        TXS_ACKED = 1'b1
    } txs_t;
endpackage

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int N  = NSRC,
    localparam int CW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] code
);
    always_comb begin
        any  = 1'b0;
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any  = 1'b1;
                code = CW'(i);
            end
        end
    end
endmodule

// File: rtl/uirq_txack.sv
module uirq_txack
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_cond,
    input  logic tx_en,
    input  logic rd_clr,
    output logic tx_pend
);
    txs_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_LIVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TXS_LIVE:  if (tx_cond && rd_clr) state_nx = TXS_ACKED;
            TXS_ACKED: if (!tx_cond)          state_nx = TXS_LIVE;
            default:                          state_nx = TXS_LIVE;
        endcase
    end

    always_comb begin
        tx_pend = 1'b0;
        unique case (state)
            TXS_LIVE:  tx_pend = tx_cond && tx_en && !rd_clr;
            TXS_ACKED: tx_pend = 1'b0;
            default:   tx_pend = 1'b0;
        endcase
    end

    p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXS_ACKED && tx_cond) |-> !tx_pend);
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_en,
    input  logic             c_rxerr,
    input  logic             c_rxdat,
    input  logic             c_tmo,
    input  logic             c_txreq,
    input  logic             c_modem,
    input  logic             fifo_mode,
    input  logic             ab_lock,
    input  logic             rd_stb,
    output logic [REG_W-1:0] id_reg,
    output logic             irq
);
    localparam logic [REG_W-1:0] ID_RESET = 8'h01;
    localparam logic [3:0]       NIB_TX   = {1'b0, CODE_TX, 1'b0};

    logic              tx_shown, tx_pend, tmo_pend, any;
    logic [NSRC-1:0]   req;
    logic [CODE_W-1:0] code;
    logic [REG_W-1:0]  id_nx;

    assign tx_shown = (id_reg[3:0] == NIB_TX);
    assign tmo_pend = c_tmo && fifo_mode && src_en[CODE_RX];

    uirq_txack u_txack (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_cond (c_txreq),
        .tx_en   (src_en[CODE_TX]),
        .rd_clr  (rd_stb && tx_shown),
        .tx_pend (tx_pend)
    );

    always_comb begin
        req           = '0;
        req[CODE_ERR] = c_rxerr && src_en[CODE_ERR];
        req[CODE_RX]  = (c_rxdat && src_en[CODE_RX]) || tmo_pend;
        req[CODE_TX]  = tx_pend;
        req[CODE_MODEM] = c_modem && src_en[CODE_MODEM];
    end

    uirq_prio #(.N(NSRC)) u_prio (
        .req  (req),
        .any  (any),
        .code (code)
    );

    always_comb begin
        id_nx    = '0;
        id_nx[0] = !any;
        if (any) begin
            id_nx[2:1] = code;
            id_nx[3]   = tmo_pend && (code == CODE_RX);
        end
        id_nx[4] = ab_lock;
        id_nx[5] = 1'b0;
        id_nx[7:6] = {2{fifo_mode}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_reg <= ID_RESET;
            irq    <= 1'b0;
        end else begin
            id_reg <= id_nx;
            irq    <= any;
        end
    end

    p_err_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rxerr && src_en[CODE_ERR]) |=> (id_reg[3:0] == 4'h6));
    p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        id_reg[0] |-> (id_reg[3:1] == 3'b000));
    p_nofifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> (id_reg[7:6] == 2'b00 && !id_reg[3]));
    p_ablock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ab_lock |=> id_reg[4]);
    p_txclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && tx_shown) |=> (id_reg[3:0] != NIB_TX));
endmodule

// File: tb/uirq_ident_bench.sv
`timescale 1ns/1ps
module uirq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_en = '0;
    logic       c_rxerr = 0, c_rxdat = 0, c_tmo = 0, c_txreq = 0, c_modem = 0;
    logic       fifo_mode = 0, ab_lock = 0, rd_stb = 0;
    logic [7:0] id_reg;
    logic       irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;
    logic [7:0] exp_id = 8'h01;
    bit  acked = 0;

    always #2 clk = ~clk;

    uirq_ident u_uirq_ident (
        .clk(clk), .rst_n(rst_n), .src_en(src_en),
        .c_rxerr(c_rxerr), .c_rxdat(c_rxdat), .c_tmo(c_tmo),
        .c_txreq(c_txreq), .c_modem(c_modem),
        .fifo_mode(fifo_mode), .ab_lock(ab_lock), .rd_stb(rd_stb),
        .id_reg(id_reg), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // cnd = {err, rxdat, tmo, txreq, modem}
    task automatic step(input logic [3:0] en, input logic [4:0] cnd,
                        input logic fm, input logic ab, input logic rd,
                        input string tag);
        logic [3:0] nib;
        bit shown, clr, txp;
        @(negedge clk);
        src_en = en; c_rxerr = cnd[4]; c_rxdat = cnd[3]; c_tmo = cnd[2];
        c_txreq = cnd[1]; c_modem = cnd[0];
        fifo_mode = fm; ab_lock = ab; rd_stb = rd;
        shown = (exp_id[3:0] == 4'h2);
        clr   = rd && shown;
        txp   = cnd[1] && en[1] && !acked && !clr;
        if (en[3] && cnd[4])            nib = 4'h6;
        else if (en[2] && fm && cnd[2]) nib = 4'hC;
        else if (en[2] && cnd[3])       nib = 4'h4;
        else if (txp)                   nib = 4'h2;
        else if (en[0] && cnd[0])       nib = 4'h0;
        else                            nib = 4'h1;
        if (!cnd[1])  acked = 0;
        else if (clr) acked = 1;
        @(posedge clk); #1;
        exp_id = {fm, fm, 1'b0, ab, nib};
        chk(id_reg[3:0] == exp_id[3:0], tag, int'(id_reg[3:0]), int'(exp_id[3:0]));
        chk(id_reg[0] == exp_id[0], "R2", int'(id_reg[0]), int'(exp_id[0]));
        chk(id_reg[4] == ab, "R7", int'(id_reg[4]), int'(ab));
        chk(id_reg[7:5] == exp_id[7:5], "R8", int'(id_reg[7:5]), int'(exp_id[7:5]));
        chk(irq == !exp_id[0], "R11", int'(irq), int'(!exp_id[0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(id_reg == 8'h01, "R1", int'(id_reg), 8'h01);
        chk(irq == 1'b0, "R1", int'(irq), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(id_reg == 8'h01, "R1", int'(id_reg), 8'h01);

        // Exhaustive sweep: priority against the model
        for (int fm = 0; fm < 2; fm++)
            for (int en = 0; en < 16; en++)
                for (int c = 0; c < 32; c++)
                    step(4'(en), 5'(c), 1'(fm), 1'(en ^ c), (c % 3) == 0, "R4");

        // Each code alone (R3)
        step(4'hF, 5'b10000, 1'b0, 1'b0, 1'b0, "R3");
        step(4'hF, 5'b01000, 1'b0, 1'b0, 1'b0, "R3");
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b0, "R3");
        step(4'hF, 5'b00001, 1'b0, 1'b0, 1'b0, "R3");
        step(4'hF, 5'b00000, 1'b0, 1'b0, 1'b0, "R3");
        // Time-out (R5): ignored outside FIFO mode, 0xC inside
        step(4'hF, 5'b00100, 1'b0, 1'b0, 1'b0, "R5");
        step(4'hF, 5'b01100, 1'b1, 1'b0, 1'b0, "R5");
        step(4'hB, 5'b00100, 1'b1, 1'b0, 1'b0, "R5");
        // Disabled sources (R6)
        step(4'h0, 5'b11111, 1'b1, 1'b1, 1'b0, "R6");
        step(4'h0, 5'b00000, 1'b0, 1'b0, 1'b0, "R6");
        // Acknowledge and re-arm of transmit (R9)
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b0, "R9");
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b1, "R9");
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b0, "R9");
        step(4'hF, 5'b00011, 1'b0, 1'b0, 1'b0, "R9");
        step(4'hF, 5'b00000, 1'b0, 1'b0, 1'b0, "R9");
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b0, "R9");
        // Read while a higher source is shown (R10)
        step(4'hF, 5'b01010, 1'b0, 1'b0, 1'b0, "R10");
        step(4'hF, 5'b01010, 1'b0, 1'b0, 1'b1, "R10");
        step(4'hF, 5'b00010, 1'b0, 1'b0, 1'b0, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule